// File: doc/BRIEF.md
# Partition SAD Combiner and Best-Vector Selector

This block sits behind an integer-pel block-matching engine. For each search candidate it receives the sixteen 4x4 sub-block distortions of a 16x16 macroblock and the motion vector of that candidate. A shallow adder tree combines the sixteen values into the distortion of every partition an H.264 encoder may choose: 41 values per candidate, across seven shapes.

Each of the 41 partitions has its own running-minimum register pair, which holds a cost and a vector. All 41 are updated in the same cycle that a candidate is accepted, so the block takes one candidate per clock with no stall. A start pulse opens a new search. A last flag on the final candidate makes the block raise a one-cycle done strobe, and the 41 winning vectors and their costs are then held until the next start.

A high-definition mode, sampled at start, marks the partitions smaller than 8x8 as not valid for that search.

Top module: `vbs_sad_select`

## Requirements
- R1: The input `sad4_i` holds sixteen 12-bit distortions. Block k = row*4+col sits at bits [k*12 +: 12], with row 0 at the top. The 41 partition costs are sums of the 4x4 values they cover. They appear in this slot order: 0-15 are the 4x4 blocks in raster order; 16-23 are the 8x4 blocks (8 wide, 4 tall), indexed row*2+col; 24-31 are the 4x8 blocks, indexed row*4+col; 32-35 are the 8x8 blocks, indexed row*2+col; 36-37 are 16x8 top then bottom; 38-39 are 8x16 left then right; 40 is 16x16. Each slot is COST_W=16 bits at [p*16 +: 16].
- R2: A partition's cost and vector are replaced only when an accepted candidate's cost is strictly lower than the held cost. On equal costs, the earlier candidate is kept.
- R3: A start pulse sets every held cost to all ones (0xFFFF) and every vector to 0. A candidate accepted in the same cycle as start is compared against all ones and becomes the first entry of the new search.
- R4: `done_o` is high for exactly the one cycle after the clock edge that accepts a candidate with `cand_last_i` set. At that point the outputs include that candidate. The outputs then stay unchanged until the next start or accepted candidate.
- R5: `hd_mode_i` is sampled on start. While the sampled value is 1, `part_valid_o` bits 0-31 are 0 and bits 32-40 are 1. While it is 0, all 41 bits are 1.
- R6: Each partition's vector `best_mv_o[p*16 +: 16]` is the `mv_i` of the candidate whose cost it holds.
- R7: Cycles with `cand_valid_i` low change no held cost or vector.
- R8: After reset, all costs are 0xFFFF, all vectors are 0, `done_o` is 0 and `part_valid_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new search; clears the minimums |
| hd_mode_i | input | 1 | Restrict the valid results to 8x8 and larger; sampled on start |
| cand_valid_i | input | 1 | A candidate is presented and accepted this cycle |
| cand_last_i | input | 1 | The presented candidate is the last of the search |
| sad4_i | input | 192 | Sixteen 12-bit 4x4 distortions |
| mv_i | input | 16 | Motion vector of the candidate |
| done_o | output | 1 | One-cycle strobe: the final results are present |
| part_valid_o | output | 41 | Per-partition result-valid mask |
| best_cost_o | output | 656 | 41 minimum costs, 16 bits each |
| best_mv_o | output | 656 | 41 winning vectors, 16 bits each |

## Verification
A candidate driven before clock edge k is in the held results after edge k. `done_o` for the last candidate is high in the cycle that follows edge k. The bench drives inputs on falling edges and pushes the 41 expected costs, vectors and mask bits into a queue before the final edge. The monitor samples on falling edges: when it sees `done_o` it pops and compares all 41 entries, and it compares them again three cycles later to confirm that the results hold. The start-only check samples one cycle after start.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  localparam int unsigned N_BLK     = 16;
  localparam int unsigned N_PART    = 41;
  localparam int unsigned IDX_8X4   = 16;
  localparam int unsigned IDX_4X8   = 24;
  localparam int unsigned IDX_8X8   = 32;
  localparam int unsigned IDX_16X8  = 36;
  localparam int unsigned IDX_8X16  = 38;
  localparam int unsigned IDX_16X16 = 40;
  localparam int unsigned N_SMALL   = 32; // slots below 8x8
endpackage

// File: rtl/vbs_sad_tree.sv
module vbs_sad_tree
  import vbs_pkg::*;
#(
  parameter int unsigned SAD_W  = 12,
  parameter int unsigned COST_W = 16
) (
  input  logic [N_BLK*SAD_W-1:0]   sad4_i,
  output logic [N_PART*COST_W-1:0] part_sad_o
);
  logic [COST_W-1:0] s44  [16];
  logic [COST_W-1:0] s84  [8];
  logic [COST_W-1:0] s48  [8];
  logic [COST_W-1:0] s88  [4];
  logic [COST_W-1:0] s168 [2];
  logic [COST_W-1:0] s816 [2];
  logic [COST_W-1:0] s1616;

  for (genvar b = 0; b < 16; b++) begin : g_leaf
    assign s44[b] = COST_W'(sad4_i[b*SAD_W +: SAD_W]);
    assign part_sad_o[b*COST_W +: COST_W] = s44[b];
  end

  for (genvar r = 0; r < 4; r++) begin : g_84r
    for (genvar c = 0; c < 2; c++) begin : g_84c
      assign s84[r*2+c] = s44[r*4+2*c] + s44[r*4+2*c+1];
      assign part_sad_o[(IDX_8X4+r*2+c)*COST_W +: COST_W] = s84[r*2+c];
    end
  end

  for (genvar r = 0; r < 2; r++) begin : g_48r
    for (genvar c = 0; c < 4; c++) begin : g_48c
      assign s48[r*4+c] = s44[8*r+c] + s44[8*r+4+c];
      assign part_sad_o[(IDX_4X8+r*4+c)*COST_W +: COST_W] = s48[r*4+c];
    end
  end

  // 8x8 reuses the 8x4 pair stacked vertically
  for (genvar r = 0; r < 2; r++) begin : g_88r
    for (genvar c = 0; c < 2; c++) begin : g_88c
      assign s88[r*2+c] = s84[4*r+c] + s84[4*r+2+c];
      assign part_sad_o[(IDX_8X8+r*2+c)*COST_W +: COST_W] = s88[r*2+c];
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_half
    assign s168[i] = s88[2*i] + s88[2*i+1];
    assign s816[i] = s88[i] + s88[2+i];
    assign part_sad_o[(IDX_16X8+i)*COST_W +: COST_W] = s168[i];
    assign part_sad_o[(IDX_8X16+i)*COST_W +: COST_W] = s816[i];
  end

  assign s1616 = s168[0] + s168[1];
  assign part_sad_o[IDX_16X16*COST_W +: COST_W] = s1616;
endmodule

// File: rtl/vbs_min_track.sv
module vbs_min_track #(
  parameter int unsigned COST_W = 16,
  parameter int unsigned MV_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              take_i,
  input  logic [COST_W-1:0] cost_i,
  input  logic [MV_W-1:0]   mv_i,
  output logic [COST_W-1:0] best_cost_o,
  output logic [MV_W-1:0]   best_mv_o
);
  logic [COST_W-1:0] cost_q, base;
  logic [MV_W-1:0]   mv_q;

  // a start in the same cycle compares against the cleared value
  assign base = start_i ? '1 : cost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cost_q <= '1;
      mv_q   <= '0;
    end else if (take_i && (cost_i < base)) begin
      cost_q <= cost_i;
      mv_q   <= mv_i;
    end else if (start_i) begin
      cost_q <= '1;
      mv_q   <= '0;
    end
  end

  assign best_cost_o = cost_q;
  assign best_mv_o   = mv_q;

  a_r2_never_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !start_i |=> cost_q <= $past(cost_q));
  a_r2_tie_keeps_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !start_i && (cost_i >= cost_q) |=> $stable(mv_q) && $stable(cost_q));
  a_r3_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !take_i |=> (cost_q == '1) && (mv_q == '0));
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i && !start_i |=> $stable(cost_q) && $stable(mv_q));
endmodule

// File: rtl/vbs_sad_select.sv
module vbs_sad_select
  import vbs_pkg::*;
#(
  parameter int unsigned SAD_W  = 12,
  parameter int unsigned COST_W = 16,
  parameter int unsigned MV_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     hd_mode_i,
  input  logic                     cand_valid_i,
  input  logic                     cand_last_i,
  input  logic [N_BLK*SAD_W-1:0]   sad4_i,
  input  logic [MV_W-1:0]          mv_i,
  output logic                     done_o,
  output logic [N_PART-1:0]        part_valid_o,
  output logic [N_PART*COST_W-1:0] best_cost_o,
  output logic [N_PART*MV_W-1:0]   best_mv_o
);
  logic [N_PART*COST_W-1:0] part_sad;
  logic done_q, hd_q;

  vbs_sad_tree #(.SAD_W(SAD_W), .COST_W(COST_W)) u_tree (
    .sad4_i     (sad4_i),
    .part_sad_o (part_sad)
  );

  for (genvar p = 0; p < N_PART; p++) begin : g_trk
    vbs_min_track #(.COST_W(COST_W), .MV_W(MV_W)) u_trk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .take_i      (cand_valid_i),
      .cost_i      (part_sad[p*COST_W +: COST_W]),
      .mv_i        (mv_i),
      .best_cost_o (best_cost_o[p*COST_W +: COST_W]),
      .best_mv_o   (best_mv_o[p*MV_W +: MV_W])
    );
    assign part_valid_o[p] = (p >= N_SMALL) || !hd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      hd_q   <= 1'b0;
    end else begin
      done_q <= cand_valid_i && cand_last_i;
      if (start_i) hd_q <= hd_mode_i;
    end
  end

  assign done_o = done_q;

  a_r4_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_i && cand_last_i |=> done_o);
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cand_valid_i && cand_last_i) |=> !done_o);
  a_r1_tree_paths_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_i |-> part_sad[IDX_16X16*COST_W +: COST_W] ==
      part_sad[IDX_8X16*COST_W +: COST_W] + part_sad[(IDX_8X16+1)*COST_W +: COST_W]);
  a_r5_mask_follows_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (part_valid_o[0] == !$past(hd_mode_i)) && part_valid_o[N_PART-1]);
endmodule

// File: tb/tb_vbs_sad_select.sv
`timescale 1ns/1ps
module tb_vbs_sad_select;
  localparam int SAD_W = 12, COST_W = 16, MV_W = 16, NP = 41;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, hd_mode_i = 1'b0, cand_valid_i = 1'b0, cand_last_i = 1'b0;
  logic [16*SAD_W-1:0] sad4_i = '0;
  logic [MV_W-1:0] mv_i = '0;
  logic done_o;
  logic [NP-1:0] part_valid_o;
  logic [NP*COST_W-1:0] best_cost_o;
  logic [NP*MV_W-1:0] best_mv_o;

  always #10 clk = ~clk;

  vbs_sad_select dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .hd_mode_i(hd_mode_i),
    .cand_valid_i(cand_valid_i), .cand_last_i(cand_last_i), .sad4_i(sad4_i),
    .mv_i(mv_i), .done_o(done_o), .part_valid_o(part_valid_o),
    .best_cost_o(best_cost_o), .best_mv_o(best_mv_o)
  );

  int errors = 0, checks = 0;
  int searches_in = 0, searches_out = 0;
  int gx[NP], gy[NP], gw[NP], gh[NP];
  int exp_cost_q[$], exp_mv_q[$], exp_pv_q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cost_at(int p); return int'(best_cost_o[p*COST_W +: COST_W]); endfunction
  function automatic int mv_at(int p);   return int'(best_mv_o[p*MV_W +: MV_W]);       endfunction

  // partition geometry in 4x4 units, slot order of R1
  initial begin
    int ws[7] = '{1, 2, 1, 2, 4, 2, 4};
    int hs[7] = '{1, 1, 2, 2, 2, 4, 4};
    int k = 0;
    for (int s = 0; s < 7; s++)
      for (int r = 0; r < 4 / hs[s]; r++)
        for (int c = 0; c < 4 / ws[s]; c++) begin
          gx[k] = c * ws[s]; gy[k] = r * hs[s]; gw[k] = ws[s]; gh[k] = hs[s];
          k++;
        end
  end

  // mode 0 random, 1 identical candidates (ties), 2 all-max values
  task automatic run_search(int ncand, bit hd, int mode, bit gaps, bit start_with_first);
    int mc[NP], mm[NP], s[16], tie[16];
    for (int p = 0; p < NP; p++) begin mc[p] = 65535; mm[p] = 0; end
    for (int b = 0; b < 16; b++) tie[b] = $urandom_range(0, 4095);
    searches_in++;
    @(negedge clk);
    start_i = 1'b1; hd_mode_i = hd;
    if (!start_with_first) begin @(negedge clk); start_i = 1'b0; end
    for (int i = 0; i < ncand; i++) begin
      if (gaps && (i % 3 == 1)) begin
        cand_valid_i = 1'b0;
        sad4_i = '0;           // a bubble with zero costs must not win (R7)
        @(negedge clk); start_i = 1'b0;
      end
      for (int b = 0; b < 16; b++) begin
        s[b] = (mode == 1) ? tie[b] : (mode == 2) ? 4095 : int'($urandom_range(0, 4095));
        sad4_i[b*SAD_W +: SAD_W] = SAD_W'(s[b]);
      end
      mv_i = MV_W'((searches_in << 8) | i);
      cand_valid_i = 1'b1;
      cand_last_i = (i == ncand - 1);
      for (int p = 0; p < NP; p++) begin
        int sum = 0;
        for (int y = gy[p]; y < gy[p] + gh[p]; y++)
          for (int x = gx[p]; x < gx[p] + gw[p]; x++) sum += s[y*4+x];
        if (sum < mc[p]) begin mc[p] = sum; mm[p] = int'(mv_i); end
      end
      if (i == ncand - 1)
        for (int p = 0; p < NP; p++) begin
          exp_cost_q.push_back(mc[p]);
          exp_mv_q.push_back(mm[p]);
          exp_pv_q.push_back((hd && p < 32) ? 0 : 1);
        end
      @(negedge clk);
      start_i = 1'b0;
    end
    cand_valid_i = 1'b0; cand_last_i = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin
        int ec[NP], em[NP], ep[NP];
        searches_out++;
        if (exp_cost_q.size() < NP) begin
          chk(0, "R4", "done without pending search", searches_out, searches_in);
        end else begin
          for (int p = 0; p < NP; p++) begin
            ec[p] = exp_cost_q.pop_front(); em[p] = exp_mv_q.pop_front(); ep[p] = exp_pv_q.pop_front();
            chk(cost_at(p) == ec[p], "R1", $sformatf("cost slot %0d", p), cost_at(p), ec[p]);
            chk(mv_at(p) == em[p], "R2/R6", $sformatf("vector slot %0d", p), mv_at(p), em[p]);
            chk(int'(part_valid_o[p]) == ep[p], "R5", $sformatf("valid slot %0d", p), int'(part_valid_o[p]), ep[p]);
          end
          repeat (3) @(negedge clk);
          chk(!done_o, "R4", "done is a single pulse", int'(done_o), 0);
          for (int p = 0; p < NP; p++) begin
            chk(cost_at(p) == ec[p], "R4", $sformatf("held cost slot %0d", p), cost_at(p), ec[p]);
            chk(mv_at(p) == em[p], "R4", $sformatf("held vector slot %0d", p), mv_at(p), em[p]);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R4 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!done_o, "R8", "done in reset", int'(done_o), 0);
    chk(part_valid_o == '1, "R8", "valid mask in reset", int'(part_valid_o[0]), 1);
    for (int p = 0; p < NP; p++) begin
      chk(cost_at(p) == 65535, "R8", $sformatf("reset cost slot %0d", p), cost_at(p), 65535);
      chk(mv_at(p) == 0, "R8", $sformatf("reset vector slot %0d", p), mv_at(p), 0);
    end
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    run_search(20, 1'b0, 0, 1'b0, 1'b0);   // R1 R2 R6 random
    run_search(6,  1'b0, 1, 1'b0, 1'b0);   // R2 ties keep first vector
    run_search(15, 1'b1, 0, 1'b1, 1'b1);   // R3 start with first, R5 hd, R7 bubbles

    // R3: a start alone clears everything; R5 mask back to all ones
    @(negedge clk); start_i = 1'b1; hd_mode_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    for (int p = 0; p < NP; p++) begin
      chk(cost_at(p) == 65535, "R3", $sformatf("cleared cost slot %0d", p), cost_at(p), 65535);
      chk(mv_at(p) == 0, "R3", $sformatf("cleared vector slot %0d", p), mv_at(p), 0);
    end
    chk(part_valid_o == '1, "R5", "mask with hd off", int'(part_valid_o[0]), 1);

    run_search(1,  1'b0, 2, 1'b0, 1'b0);   // R1 maximum sums (16x16 = 65520)
    run_search(30, 1'b0, 0, 1'b1, 1'b0);   // R7 bubbles, longer stream
    run_search(9,  1'b1, 1, 1'b1, 1'b1);   // R2 ties under hd mode

    repeat (10) @(negedge clk);
    chk(searches_out == searches_in, "R4", "done strobes per search", searches_out, searches_in);
    chk(exp_cost_q.size() == 0, "R4", "unconsumed expectations", exp_cost_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule